// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block drives a multichannel analog-to-digital converter that is controlled over a four-wire serial link and answers one frame late. For each request it pulls chip select low and waits a set-up time. It then toggles the serial clock exactly twelve times. On the data line it sends the channel number and control nibble of the new request, and at the same time it gathers the twelve result bits of the conversion started by the frame before. After the last falling clock edge it raises chip select. It waits for the converter's end-of-conversion line to go low and then high again. Only then does it accept another request.

A result always belongs to the request one frame earlier, so the sequencer holds the channel of each accepted request in a one-deep pipeline. It labels each incoming word with the channel held there. Some results are not trusted: the first one after reset, and the ones around the converter's return from power-down. These results are dropped and never strobed as valid. Raising chip select between every frame also serves as the resynchronisation path, so a reset in the middle of a frame leaves the link ready for a clean new frame.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is high, and after it, `adc_cs_n` is 1, `adc_sclk` is 0 and `res_valid` is 0. `req_ready` is 1 within four clocks of reset release when `adc_eoc` is high.
- R2: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. At that edge `adc_cs_n` goes low and `req_ready` goes low. The first rising `adc_sclk` edge comes exactly CS_SETUP clocks after chip select falls.
- R3: Each chip-select-low window holds exactly FRAME_BITS (12) rising `adc_sclk` edges, spaced 2*HALF_DIV clocks apart. `adc_sclk` is low whenever `adc_cs_n` is high.
- R4: On `adc_din`, the sequencer first sends `req_chan` (bit 3 first) and then `req_ctrl` (bit 3 first), followed by zeros up to twelve bits. `adc_din` changes only when chip select falls or on a falling `adc_sclk` edge, so it is stable at every rising edge.
- R5: `adc_dout` is sampled on each rising `adc_sclk` edge, and the first bit sampled is the result MSB. `res_data` is the twelve-bit word built from these samples.
- R6: `res_valid` is a one-clock pulse in the same clock where `adc_cs_n` rises, HALF_DIV clocks after the twelfth falling `adc_sclk` edge. `res_chan` is the `req_chan` of the request accepted in the frame before.
- R7: The frame that follows reset never produces `res_valid`.
- R8: After a one-clock pulse on `adc_wake` while idle, the next two completed frames produce no `res_valid`. The third frame reports the result and channel of the second.
- R9: Once `adc_cs_n` has risen, `req_ready` stays 0 and chip select stays high until `adc_eoc` has been seen low and then high. Chip select falls only more than CS_IDLE clocks after `adc_eoc` rises.
- R10: Reset asserted in the middle of a frame drives `adc_cs_n` high and `adc_sclk` low at the next clock. It also empties the tag pipeline, so the next frame produces no result and the one after reports the first post-reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A conversion request is offered |
| req_chan | input | CHAN_W | Channel number to convert |
| req_ctrl | input | CTRL_W | Control nibble sent after the channel |
| req_ready | output | 1 | Sequencer is idle and will take a request |
| adc_wake | input | 1 | Pulse: converter has just left power-down |
| res_valid | output | 1 | One-clock strobe for a trusted result |
| res_data | output | FRAME_BITS | Result word, MSB first on the wire |
| res_chan | output | CHAN_W | Channel the result belongs to |
| adc_cs_n | output | 1 | Chip select to the converter, active low |
| adc_sclk | output | 1 | Serial I/O clock, idles low |
| adc_din | output | 1 | Address and control bits to the converter |
| adc_dout | input | 1 | Result bits from the converter |
| adc_eoc | input | 1 | End-of-conversion from the converter |

## Verification
A result is due in the clock where chip select rises, which is HALF_DIV clocks after the twelfth falling serial edge. The bench therefore waits for the rising edge of `adc_cs_n`, samples 5 ns later, and checks one clock later that the strobe has gone away. Set-up, bit spacing and tail lengths are measured as time differences between pin edges recorded by the converter model, and compared with exact multiples of the 20 ns clock. Dropped results are confirmed at the ports, through a running count of strobes observed away from the clock edge.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_GAP
  } seq_state_t;

  // width able to hold values 0..v
  function automatic int unsigned cnt_bits(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/adc_phase_timer.sv
`timescale 1ns/1ps
module adc_phase_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && done) |=> done);

endmodule

// File: rtl/adc_shift_io.sv
`timescale 1ns/1ps
module adc_shift_io #(
  parameter int unsigned FRAME_BITS = 12,
  parameter int unsigned CMD_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [CMD_W-1:0]      cmd,
  input  logic                  shift_out,
  input  logic                  sample_in,
  input  logic                  adc_dout,
  output logic                  adc_din,
  output logic [FRAME_BITS-1:0] rx_word
);

  logic [FRAME_BITS-1:0] load_word;
  logic [FRAME_BITS-1:0] tx_sr;
  logic [FRAME_BITS-1:0] rx_sr;

  generate
    if (FRAME_BITS > CMD_W) begin : g_pad
      assign load_word = {cmd, {(FRAME_BITS - CMD_W){1'b0}}};
    end else begin : g_trunc
      assign load_word = cmd[CMD_W-1 -: FRAME_BITS];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      tx_sr <= '0;
    else if (load)
      tx_sr <= load_word;
    else if (shift_out)
      tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)
      rx_sr <= '0;
    else if (sample_in)
      rx_sr <= {rx_sr[FRAME_BITS-2:0], adc_dout};
  end

  assign adc_din = tx_sr[FRAME_BITS-1];
  assign rx_word = rx_sr;

  // R4
  din_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift_out) |=> $stable(adc_din));

endmodule

// File: rtl/adc_tag_pipe.sv
`timescale 1ns/1ps
module adc_tag_pipe #(
  parameter int unsigned CHAN_W = 4,
  parameter int unsigned RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              frame_done,
  input  logic [RES_W-1:0]  rx_word,
  input  logic              wake,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic [CHAN_W-1:0] res_chan
);

  logic [CHAN_W-1:0] cur_chan;
  logic [CHAN_W-1:0] pipe_chan;
  logic              pipe_vld;
  logic              skip_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_chan  <= '0;
      pipe_chan <= '0;
      pipe_vld  <= 1'b0;
      skip_next <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (accept)
        cur_chan <= req_chan;
      if (frame_done) begin
        res_valid <= pipe_vld & ~wake;
        res_data  <= rx_word;
        res_chan  <= pipe_chan;
        pipe_chan <= cur_chan;
        pipe_vld  <= ~skip_next & ~wake;
        skip_next <= wake;
      end else if (wake) begin
        pipe_vld  <= 1'b0;
        skip_next <= 1'b1;
      end
    end
  end

  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R6
  res_src_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(frame_done));

  // R8
  wake_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wake) |-> !res_valid);

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned CHAN_W     = 4,
  parameter int unsigned CTRL_W     = 4,
  parameter int unsigned FRAME_BITS = 12,
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned CS_SETUP   = 3,
  parameter int unsigned CS_IDLE    = 2,
  parameter int unsigned SYNC_LEN   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [CHAN_W-1:0]     req_chan,
  input  logic [CTRL_W-1:0]     req_ctrl,
  output logic                  req_ready,
  input  logic                  adc_wake,
  output logic                  res_valid,
  output logic [FRAME_BITS-1:0] res_data,
  output logic [CHAN_W-1:0]     res_chan,
  output logic                  adc_cs_n,
  output logic                  adc_sclk,
  output logic                  adc_din,
  input  logic                  adc_dout,
  input  logic                  adc_eoc
);

  localparam int unsigned CMD_W = CHAN_W + CTRL_W;
  localparam int unsigned TMAX0 = (HALF_DIV > CS_SETUP) ? HALF_DIV : CS_SETUP;
  localparam int unsigned TMAX  = (TMAX0 > CS_IDLE) ? TMAX0 : CS_IDLE;
  localparam int unsigned TW    = cnt_bits(TMAX);
  localparam int unsigned BW    = cnt_bits(FRAME_BITS);

  seq_state_t        state;
  logic              cs_n_q;
  logic              sclk_q;
  logic [BW-1:0]     bit_cnt;
  logic [SYNC_LEN-1:0] eoc_sync;
  logic              eoc_s;
  logic              accept;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              tmr_done;
  logic              sample_in;
  logic              shift_out;
  logic              frame_done;
  logic              last_bit;

  // end-of-conversion crosses in from the converter
  always_ff @(posedge clk) begin
    if (rst)
      eoc_sync <= '0;
    else
      eoc_sync <= {eoc_sync[SYNC_LEN-2:0], adc_eoc};
  end
  assign eoc_s = eoc_sync[SYNC_LEN-1];

  assign req_ready  = (state == ST_IDLE) && eoc_s;
  assign accept     = req_valid && req_ready;
  assign last_bit   = (bit_cnt == BW'(FRAME_BITS - 1));
  assign sample_in  = ((state == ST_SETUP) || (state == ST_LOW)) && tmr_done;
  assign shift_out  = (state == ST_HIGH) && tmr_done;
  assign frame_done = (state == ST_TAIL) && tmr_done;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(CS_SETUP - 1);
      end
      ST_SETUP, ST_LOW, ST_HIGH: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(HALF_DIV - 1);
      end
      ST_WAIT_HI: if (eoc_s) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(CS_IDLE - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      bit_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          cs_n_q  <= 1'b0;
          bit_cnt <= '0;
          state   <= ST_SETUP;
        end
        ST_SETUP, ST_LOW: if (tmr_done) begin
          sclk_q <= 1'b1;
          state  <= ST_HIGH;
        end
        ST_HIGH: if (tmr_done) begin
          sclk_q  <= 1'b0;
          bit_cnt <= bit_cnt + 1'b1;
          state   <= last_bit ? ST_TAIL : ST_LOW;
        end
        ST_TAIL: if (tmr_done) begin
          cs_n_q <= 1'b1;
          state  <= ST_WAIT_LO;
        end
        ST_WAIT_LO: if (!eoc_s) state <= ST_WAIT_HI;
        ST_WAIT_HI: if (eoc_s)  state <= ST_GAP;
        ST_GAP:     if (tmr_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign adc_cs_n = cs_n_q;
  assign adc_sclk = sclk_q;

  adc_phase_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  adc_shift_io #(.FRAME_BITS(FRAME_BITS), .CMD_W(CMD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .cmd       ({req_chan, req_ctrl}),
    .shift_out (shift_out),
    .sample_in (sample_in),
    .adc_dout  (adc_dout),
    .adc_din   (adc_din),
    .rx_word   (res_data_w)
  );

  logic [FRAME_BITS-1:0] res_data_w;

  adc_tag_pipe #(.CHAN_W(CHAN_W), .RES_W(FRAME_BITS)) u_tags (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .req_chan   (req_chan),
    .frame_done (frame_done),
    .rx_word    (res_data_w),
    .wake       (adc_wake),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .res_chan   (res_chan)
  );

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> !adc_sclk);

  // R3
  bit_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= BW'(FRAME_BITS));

  // R2
  cs_start_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!adc_cs_n && !req_ready));

  // R9
  eoc_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> $past(eoc_s));

  // R6
  res_edge_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (adc_cs_n && !$past(adc_cs_n)));

endmodule

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

  localparam int CHAN_W     = 4;
  localparam int CTRL_W     = 4;
  localparam int FRAME_BITS = 12;
  localparam int HALF_DIV   = 2;
  localparam int CS_SETUP   = 3;
  localparam int CS_IDLE    = 2;
  localparam int TCK        = 20;
  localparam int CONV_NS    = 503;
  localparam int NV         = 6;
  localparam logic [7:0] VEC [NV] = '{8'h0C, 8'hB3, 8'h5A, 8'hF0, 8'h77, 8'hA5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [CHAN_W-1:0] req_chan = '0;
  logic [CTRL_W-1:0] req_ctrl = '0;
  logic req_ready;
  logic adc_wake = 1'b0;
  logic res_valid;
  logic [FRAME_BITS-1:0] res_data;
  logic [CHAN_W-1:0] res_chan;
  logic adc_cs_n, adc_sclk, adc_din;
  logic m_dout = 1'b0;
  logic m_eoc  = 1'b1;

  always #10 clk = ~clk;

  adc_seq_ctrl #(
    .CHAN_W(CHAN_W), .CTRL_W(CTRL_W), .FRAME_BITS(FRAME_BITS),
    .HALF_DIV(HALF_DIV), .CS_SETUP(CS_SETUP), .CS_IDLE(CS_IDLE), .SYNC_LEN(2)
  ) i_adc_seq_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_ctrl(req_ctrl), .req_ready(req_ready), .adc_wake(adc_wake),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
    .adc_dout(m_dout), .adc_eoc(m_eoc)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_valid = 0;
  bit done_flag = 0;

  task automatic chk_eq(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [11:0] adc_value(input logic [7:0] b);
    return {b, b[7:4] ^ b[3:0]};
  endfunction

  // converter model
  logic [11:0] m_out = '0;
  logic [11:0] m_pend = '0;
  logic [11:0] m_in = '0;
  int  m_rise = 0, m_fall = 0, per_err = 0;
  time t_csfall = 0, t_first = 0, t_lastrise = 0, t_lastfall = 0;
  time t_csrise = 0, t_eocrise = 0;
  bit  armed = 0;

  always @(negedge adc_cs_n) if (armed) begin
    chk_eq("R9 eoc high at cs fall", m_eoc, 1);
    chk_eq("R9 idle gap after eoc", (($time - t_eocrise) > CS_IDLE*TCK), 1);
    m_out = m_pend; m_dout = m_pend[11];
    m_rise = 0; m_fall = 0; per_err = 0; t_csfall = $time;
  end

  always @(posedge adc_cs_n) if (armed) t_csrise = $time;

  always @(posedge adc_sclk) if (!adc_cs_n) begin
    if (m_rise == 0) t_first = $time;
    else if (($time - t_lastrise) != 2*HALF_DIV*TCK) per_err++;
    t_lastrise = $time;
    m_in = {m_in[10:0], adc_din};
    m_rise++;
  end

  always @(negedge adc_sclk) if (!adc_cs_n) begin
    m_out = {m_out[10:0], 1'b0}; m_dout = m_out[11];
    m_fall++; t_lastfall = $time;
    if (m_fall == FRAME_BITS) begin
      #3; m_eoc = 1'b0; m_pend = adc_value(m_in[11:4]);
      #(CONV_NS); m_eoc = 1'b1; t_eocrise = $time;
    end
  end

  always @(negedge clk) if (res_valid) n_valid++;

  task automatic issue(input logic [7:0] b);
    while (!req_ready) @(negedge clk);
    req_chan = b[7:4]; req_ctrl = b[3:0]; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_frame(input logic [7:0] b);
    issue(b);
    chk_eq("R2 cs low after accept", adc_cs_n, 0);
    chk_eq("R2 ready low after accept", req_ready, 0);
    @(posedge adc_cs_n); #5;
  endtask

  initial begin
    #2_000_000;
    chk_eq("watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_eq("R1 cs_n in reset", adc_cs_n, 1);
    chk_eq("R1 sclk in reset", adc_sclk, 0);
    chk_eq("R1 res_valid in reset", res_valid, 0);
    rst = 1'b0; armed = 1;
    repeat (4) @(negedge clk);
    chk_eq("R1 ready after reset", req_ready, 1);
    chk_eq("R1 cs_n after reset", adc_cs_n, 1);

    for (int i = 0; i < NV; i++) begin
      run_frame(VEC[i]);
      if (i == 0) chk_eq("R7 first result dropped", res_valid, 0);
      else begin
        chk_eq("R6 res_valid", res_valid, 1);
        chk_eq("R5 res_data", res_data, adc_value(VEC[i-1]));
        chk_eq("R6 res_chan", res_chan, VEC[i-1][7:4]);
      end
      chk_eq("R4 din frame", m_in, {VEC[i], 4'h0});
      chk_eq("R3 rising edges", m_rise, FRAME_BITS);
      chk_eq("R3 sclk period errors", per_err, 0);
      chk_eq("R2 setup time", t_first - t_csfall, CS_SETUP*TCK);
      chk_eq("R6 tail time", t_csrise - t_lastfall, HALF_DIV*TCK);
      chk_eq("R9 ready low in conversion", req_ready, 0);
      @(posedge clk); #5;
      chk_eq("R6 single-cycle strobe", res_valid, 0);
    end

    // power-down return
    @(negedge clk); adc_wake = 1'b1;
    @(negedge clk); adc_wake = 1'b0;
    begin
      int base;
      base = n_valid;
      run_frame(8'h3C);
      chk_eq("R8 first frame after wake", res_valid, 0);
      run_frame(8'h9E);
      chk_eq("R8 second frame after wake", res_valid, 0);
      chk_eq("R8 strobe count", n_valid, base);
      run_frame(8'h21);
      chk_eq("R8 third frame valid", res_valid, 1);
      chk_eq("R8 third frame data", res_data, adc_value(8'h9E));
      chk_eq("R8 third frame chan", res_chan, 4'h9);
    end

    // reset in the middle of a frame
    issue(8'h64);
    repeat (5) @(negedge adc_sclk);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk_eq("R10 cs_n after mid reset", adc_cs_n, 1);
    chk_eq("R10 sclk after mid reset", adc_sclk, 0);
    chk_eq("R10 res_valid after mid reset", res_valid, 0);
    rst = 1'b0;
    run_frame(8'h12);
    chk_eq("R10 first frame after mid reset", res_valid, 0);
    run_frame(8'h8D);
    chk_eq("R10 second frame valid", res_valid, 1);
    chk_eq("R10 second frame chan", res_chan, 4'h1);
    chk_eq("R10 second frame data", res_data, adc_value(8'h12));
    chk_eq("R4 din after reset", m_in, {8'h8D, 4'h0});

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule